// File: doc/BRIEF.md
# Interrupt Pending and Clear Logic

This block keeps the pending-interrupt status for a small processor core. Each request input sets a sticky status bit. The pending bits are gated by an enable mask, and a fixed-priority encoder turns them into a single vector and a request to the core. When the core takes the request, the block stores the granted vector and holds off further requests until the core signals a return from interrupt.

Each bit has its own clear path. Two sources are special: the peripheral I/O source and the debug-port source. Each of them clears only as a side effect of a read strobe from the register that owns it. Every other source clears in one of two ways. Software can write a 1 to its bit through the pending-register write port. The return strobe clears the bit of the vector in service and leaves every other pending bit as it was. A request that arrives in the same cycle as a clear of the same bit wins, so the bit stays set.

Top module: `irq_pend_ctrl`

## Requirements
- R1: During and straight after reset, every pending bit is 0 and `irq_valid` is 0.
- R2: A 1 on `irq_req[i]` at a clock edge makes pending bit i read 1 after that edge. The bit then stays 1 until one of its clear paths acts.
- R3: For a normal source, a `pend_wr` cycle with `pend_wdata[i]`=1 clears pending bit i. A 0 in `pend_wdata[i]` leaves bit i unchanged.
- R4: A `periph_rd` strobe clears pending bit PERIPH_IDX (default 1) and no other bit.
- R5: A `debug_rd` strobe clears pending bit DEBUG_IDX (default 6) and no other bit.
- R6: The two special bits (1 and 6 by default) ignore software writes and the return strobe. Only their own read strobe clears them.
- R7: `irq_valid` is 1 exactly when no interrupt is in service and (pending AND `irq_en`) is nonzero. `irq_vec` is then the lowest set index of that masked value.
- R8: `irq_ack` while `irq_valid` is 1 records `irq_vec` as the vector in service. `irq_valid` then stays 0 until `irq_iret`. `irq_ack` while `irq_valid` is 0 is ignored.
- R9: `irq_iret` during service clears only the recorded vector's pending bit and ends service. `irq_iret` outside service changes nothing.
- R10: If a request and a clear of the same bit arrive in the same cycle, the request wins and the bit stays 1.
- R11: `pend_rdata` always shows the pending register, with bit i for source i. A cleared bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Per-source request, sampled every edge |
| irq_en | input | NUM_SRC | Enable mask applied before priority selection |
| pend_wr | input | 1 | Write strobe for the pending register (write-one-to-clear) |
| pend_wdata | input | NUM_SRC | Write data; a 1 clears the matching normal bit |
| pend_rdata | output | NUM_SRC | Current pending register |
| periph_rd | input | 1 | Read strobe of the peripheral status register (clears the peripheral bit) |
| debug_rd | input | 1 | Read strobe of the debug data register (clears the debug bit) |
| irq_ack | input | 1 | Core accepts the offered vector |
| irq_iret | input | 1 | Core returns from the interrupt routine |
| irq_valid | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Index of the selected interrupt |

## Verification
On every clock, the assertions check four things. Requests are sticky and win over clears. Writes of ones clear normal bits and never special bits. Each read strobe clears its own special bit. Any normal bit that falls has a write or a return behind it. The assertions also check that the offered vector is the lowest enabled pending index and that no request is offered during service. Some behaviour shows only in the bench's scenarios against its reference model. That covers which bit a return clears out of several pending bits, that an acknowledge without a request is ignored, and how a special vector behaves when it is serviced and returned from.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    typedef enum logic {
        SVC_IDLE = 1'b0,
        SVC_BUSY = 1'b1
    } svc_state_e;

    function automatic int unsigned vec_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int unsigned NUM_SRC    = 8,
    parameter int unsigned PERIPH_IDX = 1,
    parameter int unsigned DEBUG_IDX  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic               wr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic               periph_rd,
    input  logic               debug_rd,
    input  logic [NUM_SRC-1:0] ret_clr,
    output logic [NUM_SRC-1:0] pend
);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_SRC-1:0] clr;

    always_comb begin
        clr = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (i == PERIPH_IDX) begin
                clr[i] = periph_rd;
            end else if (i == DEBUG_IDX) begin
                clr[i] = debug_rd;
            end else begin
                clr[i] = (wr & wdata[i]) | ret_clr[i];
            end
        end
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr) | req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned VEC_W   = 3
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  logic               hold,
    output logic               valid,
    output logic [VEC_W-1:0]   vec
);

    logic [NUM_SRC-1:0] masked;

    always_comb begin
        masked = pend & en;
        vec    = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (masked[i]) begin
                vec = VEC_W'(i);
            end
        end
        valid = (|masked) & ~hold;
    end

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned VEC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               offer,
    input  logic [VEC_W-1:0]   offer_vec,
    input  logic               ack,
    input  logic               iret,
    output logic               busy,
    output logic [NUM_SRC-1:0] ret_clr
);

    typedef struct packed {
        svc_state_e       state;
        logic [VEC_W-1:0] vec;
    } svc_t;

    svc_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ret_clr = '0;
        unique case (st_q.state)
            SVC_IDLE: begin
                if (ack && offer) begin
                    st_d.state = SVC_BUSY;
                    st_d.vec   = offer_vec;
                end
            end
            SVC_BUSY: begin
                if (iret) begin
                    st_d.state = SVC_IDLE;
                    for (int i = 0; i < NUM_SRC; i++) begin
                        ret_clr[i] = (st_q.vec == VEC_W'(i));
                    end
                end
            end
            default: st_d.state = SVC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: SVC_IDLE, vec: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.state == SVC_BUSY);

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_SRC    = 8,
    parameter int unsigned PERIPH_IDX = 1,
    parameter int unsigned DEBUG_IDX  = 6,
    localparam int unsigned VEC_W     = vec_width(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               pend_wr,
    input  logic [NUM_SRC-1:0] pend_wdata,
    output logic [NUM_SRC-1:0] pend_rdata,
    input  logic               periph_rd,
    input  logic               debug_rd,
    input  logic               irq_ack,
    input  logic               irq_iret,
    output logic               irq_valid,
    output logic [VEC_W-1:0]   irq_vec
);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] ret_clr;
    logic               busy;

    irq_pend_bank #(
        .NUM_SRC   (NUM_SRC),
        .PERIPH_IDX(PERIPH_IDX),
        .DEBUG_IDX (DEBUG_IDX)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .wr       (pend_wr),
        .wdata    (pend_wdata),
        .periph_rd(periph_rd),
        .debug_rd (debug_rd),
        .ret_clr  (ret_clr),
        .pend     (pend)
    );

    irq_prio_sel #(
        .NUM_SRC(NUM_SRC),
        .VEC_W  (VEC_W)
    ) u_sel (
        .pend (pend),
        .en   (irq_en),
        .hold (busy),
        .valid(irq_valid),
        .vec  (irq_vec)
    );

    irq_svc_track #(
        .NUM_SRC(NUM_SRC),
        .VEC_W  (VEC_W)
    ) u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .offer    (irq_valid),
        .offer_vec(irq_vec),
        .ack      (irq_ack),
        .iret     (irq_iret),
        .busy     (busy),
        .ret_clr  (ret_clr)
    );

    assign pend_rdata = pend;

endmodule

// File: rtl/irq_pend_ctrl_chk.sv
module irq_pend_ctrl_chk #(
    parameter int unsigned NUM_SRC    = 8,
    parameter int unsigned PERIPH_IDX = 1,
    parameter int unsigned DEBUG_IDX  = 6,
    parameter int unsigned VEC_W      = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [NUM_SRC-1:0] irq_en,
    input logic               pend_wr,
    input logic [NUM_SRC-1:0] pend_wdata,
    input logic [NUM_SRC-1:0] pend_rdata,
    input logic               periph_rd,
    input logic               debug_rd,
    input logic               irq_ack,
    input logic               irq_iret,
    input logic               irq_valid,
    input logic [VEC_W-1:0]   irq_vec
);

    localparam logic [NUM_SRC-1:0] SPECIAL =
        (NUM_SRC'(1) << PERIPH_IDX) | (NUM_SRC'(1) << DEBUG_IDX);

    logic [NUM_SRC-1:0] masked;
    logic [NUM_SRC-1:0] below;
    assign masked = pend_rdata & irq_en;
    assign below  = (NUM_SRC'(1) << irq_vec) - NUM_SRC'(1);

    // R1
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pend_rdata == '0 && !irq_valid));

    // R2 and R10: a request always lands, whatever clear arrives with it
    assert_req_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req != '0) |=> ((pend_rdata & $past(irq_req)) == $past(irq_req)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_wr |=> ((pend_rdata & $past(pend_wdata & ~irq_req & ~SPECIAL)) == '0));

    assert_periph_rd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_rd && !irq_req[PERIPH_IDX]) |=> !pend_rdata[PERIPH_IDX]);

    assert_debug_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_rd && !irq_req[DEBUG_IDX]) |=> !pend_rdata[DEBUG_IDX]);

    assert_periph_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_rdata[PERIPH_IDX] && !periph_rd) |=> pend_rdata[PERIPH_IDX]);

    assert_debug_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_rdata[DEBUG_IDX] && !debug_rd) |=> pend_rdata[DEBUG_IDX]);

    assert_vec_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (masked[irq_vec] && ((masked & below) == '0)));

    assert_no_offer_in_svc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid) |=> !irq_valid);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_fall
        if (i != PERIPH_IDX && i != DEBUG_IDX) begin : g_norm
            // R9: a normal bit only falls after a write of one or a return
            assert_fall_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pend_rdata[i]) |-> ($past(pend_wr && pend_wdata[i]) || $past(irq_iret)));
        end
    end

endmodule

bind irq_pend_ctrl irq_pend_ctrl_chk #(
    .NUM_SRC   (NUM_SRC),
    .PERIPH_IDX(PERIPH_IDX),
    .DEBUG_IDX (DEBUG_IDX),
    .VEC_W     (VEC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .irq_en    (irq_en),
    .pend_wr   (pend_wr),
    .pend_wdata(pend_wdata),
    .pend_rdata(pend_rdata),
    .periph_rd (periph_rd),
    .debug_rd  (debug_rd),
    .irq_ack   (irq_ack),
    .irq_iret  (irq_iret),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec)
);

// File: tb/irq_pend_ctrl_test.sv
module irq_pend_ctrl_test;

    localparam int N  = 8;
    localparam int PI = 1;
    localparam int DI = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_en = '0;
    logic         pend_wr = 1'b0;
    logic [N-1:0] pend_wdata = '0;
    logic [N-1:0] pend_rdata;
    logic         periph_rd = 1'b0;
    logic         debug_rd = 1'b0;
    logic         irq_ack = 1'b0;
    logic         irq_iret = 1'b0;
    logic         irq_valid;
    logic [2:0]   irq_vec;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_pend_ctrl #(.NUM_SRC(N), .PERIPH_IDX(PI), .DEBUG_IDX(DI)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .pend_wr(pend_wr), .pend_wdata(pend_wdata), .pend_rdata(pend_rdata),
        .periph_rd(periph_rd), .debug_rd(debug_rd), .irq_ack(irq_ack),
        .irq_iret(irq_iret), .irq_valid(irq_valid), .irq_vec(irq_vec)
    );

    // behavioural reference
    logic [N-1:0] m_pend = '0;
    bit           m_busy = 0;
    int           m_vec = 0;

    function automatic int low_idx(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0;
            m_busy = 0;
            m_vec  = 0;
        end else begin
            logic [N-1:0] clr;
            int cur;
            clr = '0;
            cur = low_idx(m_pend & irq_en);
            if (pend_wr) clr = clr | pend_wdata;
            if (m_busy && irq_iret) clr[m_vec] = 1'b1;
            clr[PI] = periph_rd;
            clr[DI] = debug_rd;
            if (m_busy && irq_iret) m_busy = 0;
            else if (!m_busy && irq_ack && cur >= 0) begin
                m_busy = 1;
                m_vec  = cur;
            end
            m_pend = (m_pend & ~clr) | irq_req;
        end
    end

    task automatic check(input int got, input int exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    // per-cycle comparison with the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int cur;
            cur = m_busy ? -1 : low_idx(m_pend & irq_en);
            check(int'(pend_rdata), int'(m_pend), "R11 model pending");
            check(int'(irq_valid), int'(cur >= 0), "R7 model valid");
            if (cur >= 0) check(int'(irq_vec), cur, "R7 model vector");
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        irq_req = '0; pend_wr = 0; pend_wdata = '0;
        periph_rd = 0; debug_rd = 0; irq_ack = 0; irq_iret = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(int'(pend_rdata), 0, "R1 pending in reset");
        check(int'(irq_valid), 0, "R1 valid in reset");
        @(posedge clk); #2; rst_n = 1; irq_en = 8'hFF;
        @(negedge clk);
        check(int'(pend_rdata), 0, "R1 pending after reset");

        irq_req = 8'hA0; step();
        check(int'(pend_rdata), 8'hA0, "R2 set");
        check(int'(irq_vec), 5, "R7 lowest index");
        step();
        check(int'(pend_rdata), 8'hA0, "R2 sticky");
        irq_en = 8'hDF; #1;
        check(int'(irq_vec), 7, "R7 masked bit skipped");
        irq_en = 8'h00; #1;
        check(int'(irq_valid), 0, "R7 all masked");
        irq_en = 8'hFF;

        pend_wr = 1; pend_wdata = 8'h20; step();
        check(int'(pend_rdata), 8'h80, "R3 write one clears");
        pend_wr = 1; pend_wdata = 8'h00; step();
        check(int'(pend_rdata), 8'h80, "R3 write zero no effect");

        irq_req = 8'h42; step();
        check(int'(pend_rdata), 8'hC2, "R2 special set");
        pend_wr = 1; pend_wdata = 8'h42; step();
        check(int'(pend_rdata), 8'hC2, "R6 write ignored on special");
        periph_rd = 1; step();
        check(int'(pend_rdata), 8'hC0, "R4 periph read clear");
        debug_rd = 1; step();
        check(int'(pend_rdata), 8'h80, "R5 debug read clear");

        irq_en = 8'h00; irq_ack = 1; step();
        irq_en = 8'hFF; #1;
        check(int'(irq_valid), 1, "R8 ack without offer ignored");

        irq_req = 8'h14; step();
        check(int'(irq_vec), 2, "R7 vector two");
        irq_ack = 1; step();
        check(int'(irq_valid), 0, "R8 no offer in service");
        irq_iret = 1; step();
        check(int'(pend_rdata), 8'h90, "R9 only serviced bit cleared");
        check(int'(irq_vec), 4, "R9 next vector offered");
        irq_iret = 1; step();
        check(int'(pend_rdata), 8'h90, "R9 return outside service");

        pend_wr = 1; pend_wdata = 8'h10; irq_req = 8'h10; step();
        check(int'(pend_rdata), 8'h90, "R10 request beats write clear");
        irq_ack = 1; step();
        irq_iret = 1; irq_req = 8'h10; step();
        check(int'(pend_rdata), 8'h90, "R10 request beats return clear");

        irq_req = 8'h02; step();
        irq_ack = 1; step();
        check(int'(irq_valid), 0, "R8 special in service");
        irq_iret = 1; step();
        check(int'(pend_rdata), 8'h92, "R6 return ignored on special");
        periph_rd = 1; irq_req = 8'h02; step();
        check(int'(pend_rdata), 8'h92, "R10 request beats read clear");
        periph_rd = 1; step();
        check(int'(pend_rdata), 8'h90, "R4 read clear after service");

        irq_req = 8'h09; step();
        pend_wr = 1; pend_wdata = 8'hFF; step();
        check(int'(pend_rdata), 8'h00, "R3 clear all normal bits");
        check(int'(irq_valid), 0, "R7 nothing pending");

        repeat (3) step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule